// File: doc/BRIEF.md
# Page Access Rights Checker

This unit decides whether one memory access may go ahead once a page table entry has already been matched, in a 32-bit MMU that walks a hashed page table. For each request it takes the segment register word selected for the access, the privilege mode of the core, the kind of access (load, store or instruction fetch), the effective address and word 1 of the matched entry. It works out which rights the page grants. It then returns either a grant or a protection fault, one cycle after the request strobe.

A protection key is picked from one of two segment flags, depending on privilege. That key is decoded together with the 2-bit protection code held in the entry, so the same code can give different rights under different keys. The segment's no-execute flag removes execute. On a grant, the unit returns entry word 1 with the referenced bit set, and with the changed bit set as well for a store. It raises a write-back request only when that word actually changes. On a denial, it returns the exception class, a status code and, for data accesses, the faulting address.

Top module: `access_rights_check`

## Requirements
- R1: The protection key is segment bit 29 when `user_mode` is 1 and segment bit 30 when `user_mode` is 0.
- R2: With key 0, protection codes (entry bits 1:0) 0, 1 and 2 give read and write, and code 3 gives read only.
- R3: With key 1, code 0 gives no read or write, codes 1 and 3 give read only, and code 2 gives read and write.
- R4: Execute is granted exactly when segment bit 28 (no-execute) is clear, for every key and code. `rights` encodes bit 0 read, bit 1 write, bit 2 execute.
- R5: `acc_kind` 0 (load) needs read, 1 (store) needs write and 2 (fetch) needs execute. Code 3 is handled as a load. The access is granted exactly when the needed right is present; otherwise `fault` is raised.
- R6: A fetch fault reports `exc_class` 1 (instruction storage), `status_code` 0x08000000 and `fault_addr` 0.
- R7: A load or store fault reports `exc_class` 2 (data storage) and `fault_addr` equal to the effective address. `status_code` is 0x0A000000 for a store and 0x08000000 for a load.
- R8: On a grant, `pte_new` equals entry word 1 with bit 8 (referenced) set, and with bit 7 (changed) set only for a store. All other bits are unchanged. On a fault, `pte_new` equals the input word and `exc_class`/`status_code`/`fault_addr` are 0 on a grant.
- R9: On a granted load or fetch, write is cleared from the reported `rights`. On a store grant and on any fault, the full decoded rights are reported.
- R10: `wb_req` is 1 only on a grant whose `pte_new` differs from the input word. It is never 1 together with `fault`.
- R11: All outputs are registered. `rsp_valid` is 1 exactly in the cycle after `req_valid`. Without a request, every other output holds its value. Reset (`rst_n` low) clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per check |
| seg_word | input | 32 | Selected segment register word |
| user_mode | input | 1 | 1 = user privilege, 0 = supervisor |
| acc_kind | input | 2 | 0 load, 1 store, 2 fetch, 3 treated as load |
| eff_addr | input | 32 | Effective address of the access |
| pte_word | input | 32 | Word 1 of the matched page table entry |
| rsp_valid | output | 1 | Result valid strobe |
| grant | output | 1 | Access allowed |
| fault | output | 1 | Protection fault |
| exc_class | output | 2 | 0 none, 1 instruction storage, 2 data storage |
| status_code | output | 32 | Fault status code |
| fault_addr | output | 32 | Faulting address for data faults |
| rights | output | 3 | Reported rights {exec, write, read} |
| pte_new | output | 32 | Updated entry word 1 |
| wb_req | output | 1 | Request to store `pte_new` back |

## Verification
The properties assume `req_valid` is a clean 0/1 strobe and that the inputs are stable around the sampling edge. They also assume `acc_kind` is taken in the same cycle as the strobe, because the checks pair each response with the access kind from the cycle before. The bench drives every input on the falling edge and holds a request for exactly one cycle. It also changes the segment, entry and access-kind inputs while no request is pending, to show that the held results stay put. Access kind 3 is used only in the table row that covers it.

// File: rtl/arc_pkg.sv
package arc_pkg;
    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        EXC_NONE  = 2'd0,
        EXC_INSTR = 2'd1,
        EXC_DATA  = 2'd2
    } exc_class_e;

    localparam int RT_RD = 0;
    localparam int RT_WR = 1;
    localparam int RT_EX = 2;
    localparam int RT_W  = 3;

    localparam int SEG_NX_BIT  = 28;
    localparam int SEG_KU_BIT  = 29;
    localparam int SEG_KS_BIT  = 30;
    localparam int PTE_REF_BIT = 8;
    localparam int PTE_CHG_BIT = 7;
    localparam int PTE_PP_LSB  = 0;

    localparam logic [31:0] ST_PROT_FETCH = 32'h0800_0000;
    localparam logic [31:0] ST_PROT_LOAD  = 32'h0800_0000;
    localparam logic [31:0] ST_PROT_STORE = 32'h0A00_0000;
endpackage

// File: rtl/arc_key_sel.sv
module arc_key_sel #(
    parameter int KU_BIT = 29,
    parameter int KS_BIT = 30,
    parameter int NX_BIT = 28,
    parameter int SEG_W  = 32
) (
    input  logic [SEG_W-1:0] seg_word,
    input  logic             user_mode,
    output logic             prot_key,
    output logic             no_exec
);
    always_comb begin
        prot_key = user_mode ? seg_word[KU_BIT] : seg_word[KS_BIT];
        no_exec  = seg_word[NX_BIT];
    end
endmodule

// File: rtl/arc_rights_dec.sv
module arc_rights_dec
    import arc_pkg::*;
(
    input  logic            prot_key,
    input  logic [1:0]      pp_code,
    input  logic            no_exec,
    output logic [RT_W-1:0] allowed
);
    always_comb begin
        allowed = '0;
        if (!prot_key) begin
            allowed[RT_RD] = 1'b1;
            allowed[RT_WR] = (pp_code != 2'd3);
        end else begin
            allowed[RT_RD] = (pp_code != 2'd0);
            allowed[RT_WR] = (pp_code == 2'd2);
        end
        allowed[RT_EX] = !no_exec;
    end
endmodule

// File: rtl/access_rights_check.sv
module access_rights_check
    import arc_pkg::*;
#(
    parameter int SEG_W  = 32,
    parameter int ADDR_W = 32,
    parameter int PTE_W  = 32,
    parameter int STAT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [SEG_W-1:0]  seg_word,
    input  logic              user_mode,
    input  logic [1:0]        acc_kind,
    input  logic [ADDR_W-1:0] eff_addr,
    input  logic [PTE_W-1:0]  pte_word,
    output logic              rsp_valid,
    output logic              grant,
    output logic              fault,
    output logic [1:0]        exc_class,
    output logic [STAT_W-1:0] status_code,
    output logic [ADDR_W-1:0] fault_addr,
    output logic [RT_W-1:0]   rights,
    output logic [PTE_W-1:0]  pte_new,
    output logic              wb_req
);
    localparam logic [PTE_W-1:0] REF_MASK = PTE_W'(1) << PTE_REF_BIT;
    localparam logic [PTE_W-1:0] CHG_MASK = PTE_W'(1) << PTE_CHG_BIT;

    typedef struct packed {
        logic              vld;
        logic              grant;
        logic              fault;
        logic [1:0]        cls;
        logic [STAT_W-1:0] status;
        logic [ADDR_W-1:0] faddr;
        logic [RT_W-1:0]   rights;
        logic [PTE_W-1:0]  pte;
        logic              wb;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    logic            prot_key;
    logic            no_exec;
    logic [RT_W-1:0] allowed;
    logic            seg_unused;

    assign seg_unused = ^{seg_word[SEG_W-1], seg_word[SEG_NX_BIT-1:0]};

    arc_key_sel #(
        .KU_BIT(SEG_KU_BIT),
        .KS_BIT(SEG_KS_BIT),
        .NX_BIT(SEG_NX_BIT),
        .SEG_W (SEG_W)
    ) u_key (
        .seg_word (seg_word),
        .user_mode(user_mode),
        .prot_key (prot_key),
        .no_exec  (no_exec)
    );

    arc_rights_dec u_dec (
        .prot_key(prot_key),
        .pp_code (pte_word[PTE_PP_LSB +: 2]),
        .no_exec (no_exec),
        .allowed (allowed)
    );

    always_comb begin
        logic            is_store;
        logic            is_fetch;
        logic            ok;
        logic [PTE_W-1:0] upd;

        rsp_d     = rsp_q;
        rsp_d.vld = req_valid;
        is_store  = (acc_kind == ACC_STORE);
        is_fetch  = (acc_kind == ACC_FETCH);
        ok        = is_store ? allowed[RT_WR] :
                    is_fetch ? allowed[RT_EX] : allowed[RT_RD];
        upd       = pte_word | REF_MASK | (is_store ? CHG_MASK : '0);

        if (req_valid) begin
            if (ok) begin
                rsp_d.grant  = 1'b1;
                rsp_d.fault  = 1'b0;
                rsp_d.cls    = EXC_NONE;
                rsp_d.status = '0;
                rsp_d.faddr  = '0;
                rsp_d.rights = allowed;
                if (!is_store) begin
                    rsp_d.rights[RT_WR] = 1'b0;
                end
                rsp_d.pte    = upd;
                rsp_d.wb     = (upd != pte_word);
            end else begin
                rsp_d.grant  = 1'b0;
                rsp_d.fault  = 1'b1;
                rsp_d.rights = allowed;
                rsp_d.pte    = pte_word;
                rsp_d.wb     = 1'b0;
                if (is_fetch) begin
                    rsp_d.cls    = EXC_INSTR;
                    rsp_d.status = STAT_W'(ST_PROT_FETCH);
                    rsp_d.faddr  = '0;
                end else begin
                    rsp_d.cls    = EXC_DATA;
                    rsp_d.status = is_store ? STAT_W'(ST_PROT_STORE)
                                            : STAT_W'(ST_PROT_LOAD);
                    rsp_d.faddr  = eff_addr;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid   = rsp_q.vld;
    assign grant       = rsp_q.grant;
    assign fault       = rsp_q.fault;
    assign exc_class   = rsp_q.cls;
    assign status_code = rsp_q.status;
    assign fault_addr  = rsp_q.faddr;
    assign rights      = rsp_q.rights;
    assign pte_new     = rsp_q.pte;
    assign wb_req      = rsp_q.wb;
endmodule

// File: rtl/arc_checker.sv
module arc_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [1:0]  acc_kind,
    input logic        rsp_valid,
    input logic        grant,
    input logic        fault,
    input logic [1:0]  exc_class,
    input logic [31:0] status_code,
    input logic [2:0]  rights,
    input logic [31:0] pte_new,
    input logic        wb_req
);
    a_r11_resp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r11_resp_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));

    a_r11_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_valid) |-> ($stable(status_code) && $stable(pte_new) && $stable(grant)));

    a_r5_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (grant != fault));

    a_r10_no_fault_with_wb: assert property (@(posedge clk) disable iff (!rst_n)
        !(fault && wb_req));

    a_r8_wb_has_ref: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> pte_new[8]);

    a_r9_nonstore_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && grant && ($past(acc_kind) != 2'd1)) |-> !rights[1]);

    a_r6_fetch_fault_code: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && fault && ($past(acc_kind) == 2'd2)) |->
        (exc_class == 2'd1 && status_code == 32'h0800_0000));
endmodule

bind access_rights_check arc_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .acc_kind   (acc_kind),
    .rsp_valid  (rsp_valid),
    .grant      (grant),
    .fault      (fault),
    .exc_class  (exc_class),
    .status_code(status_code),
    .rights     (rights),
    .pte_new    (pte_new),
    .wb_req     (wb_req)
);

// File: tb/access_rights_check_test.sv
`timescale 1ns/1ps
module access_rights_check_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [31:0] seg_word;
    logic        user_mode;
    logic [1:0]  acc_kind;
    logic [31:0] eff_addr;
    logic [31:0] pte_word;
    logic        rsp_valid, grant, fault, wb_req;
    logic [1:0]  exc_class;
    logic [31:0] status_code, fault_addr, pte_new;
    logic [2:0]  rights;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    access_rights_check uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .seg_word(seg_word),
        .user_mode(user_mode), .acc_kind(acc_kind), .eff_addr(eff_addr),
        .pte_word(pte_word), .rsp_valid(rsp_valid), .grant(grant), .fault(fault),
        .exc_class(exc_class), .status_code(status_code), .fault_addr(fault_addr),
        .rights(rights), .pte_new(pte_new), .wb_req(wb_req)
    );

    typedef struct packed {
        logic       user;
        logic       ks;
        logic       ku;
        logic       nx;
        logic [1:0] kind;
        logic [1:0] pp;
        logic       rb;
        logic       cb;
        logic       g;
        logic [2:0] rt;
    } vec_t;

    // rt = reported rights {ex, wr, rd}
    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,1'b1,1'b0,2'd0,2'd0,1'b0,1'b0,1'b1,3'b101}, // R1 R2 sup key0 load
        '{1'b0,1'b0,1'b1,1'b0,2'd1,2'd1,1'b0,1'b0,1'b1,3'b111}, // R2 store pp1
        '{1'b0,1'b0,1'b1,1'b1,2'd1,2'd3,1'b0,1'b0,1'b0,3'b001}, // R2 R4 store pp3 fault
        '{1'b1,1'b0,1'b1,1'b0,2'd0,2'd0,1'b0,1'b0,1'b0,3'b100}, // R1 R3 user key1 pp0 load
        '{1'b1,1'b0,1'b1,1'b0,2'd2,2'd0,1'b0,1'b0,1'b1,3'b100}, // R3 R5 fetch ok
        '{1'b1,1'b0,1'b1,1'b1,2'd2,2'd2,1'b0,1'b0,1'b0,3'b011}, // R4 R6 fetch nx
        '{1'b1,1'b0,1'b1,1'b0,2'd1,2'd2,1'b0,1'b0,1'b1,3'b111}, // R3 store pp2
        '{1'b1,1'b0,1'b1,1'b0,2'd1,2'd1,1'b0,1'b0,1'b0,3'b101}, // R3 R7 store pp1 fault
        '{1'b1,1'b0,1'b1,1'b0,2'd0,2'd3,1'b0,1'b0,1'b1,3'b101}, // R3 load pp3
        '{1'b0,1'b1,1'b0,1'b0,2'd1,2'd2,1'b0,1'b0,1'b1,3'b111}, // R1 sup ks
        '{1'b0,1'b1,1'b0,1'b0,2'd1,2'd3,1'b0,1'b0,1'b0,3'b101}, // R7 store fault
        '{1'b1,1'b1,1'b0,1'b0,2'd1,2'd0,1'b0,1'b0,1'b1,3'b111}, // R1 user ku=0
        '{1'b0,1'b0,1'b0,1'b0,2'd0,2'd2,1'b1,1'b0,1'b1,3'b101}, // R10 ref set already
        '{1'b0,1'b0,1'b0,1'b0,2'd1,2'd2,1'b1,1'b1,1'b1,3'b111}, // R10 both set
        '{1'b0,1'b0,1'b0,1'b0,2'd0,2'd2,1'b0,1'b1,1'b1,3'b101}, // R8 chg kept
        '{1'b0,1'b0,1'b0,1'b0,2'd3,2'd3,1'b0,1'b0,1'b1,3'b101}, // R5 kind 3
        '{1'b0,1'b0,1'b0,1'b1,2'd0,2'd0,1'b0,1'b0,1'b1,3'b001}  // R4 R9 nx load
    };

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(vec_t v, logic [31:0] ea);
        @(negedge clk);
        seg_word  = 32'h00A5_1234 | (32'(v.ks) << 30) | (32'(v.ku) << 29) | (32'(v.nx) << 28);
        user_mode = v.user;
        acc_kind  = v.kind;
        eff_addr  = ea;
        pte_word  = 32'h5A5A_3C20 | (32'(v.rb) << 8) | (32'(v.cb) << 7) | 32'(v.pp);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic verify(vec_t v, logic [31:0] ea, logic [31:0] pte_in);
        logic [31:0] exp_pte, exp_st, exp_fa;
        logic [1:0]  exp_cls;
        logic        st, fe;
        st = (v.kind == 2'd1);
        fe = (v.kind == 2'd2);
        exp_pte = v.g ? (pte_in | 32'h100 | (st ? 32'h80 : 32'h0)) : pte_in;
        exp_cls = v.g ? 2'd0 : (fe ? 2'd1 : 2'd2);
        exp_st  = v.g ? 32'h0 : (fe ? 32'h0800_0000 : (st ? 32'h0A00_0000 : 32'h0800_0000));
        exp_fa  = (v.g || fe) ? 32'h0 : ea;
        check("R11 rsp_valid", 32'(rsp_valid), 32'd1);
        check("R5 grant", 32'(grant), 32'(v.g));
        check("R5 fault", 32'(fault), 32'(!v.g));
        check("R2 R3 R4 R9 rights", 32'(rights), 32'(v.rt));
        check("R6 R7 exc_class", 32'(exc_class), 32'(exp_cls));
        check("R6 R7 status_code", status_code, exp_st);
        check("R7 fault_addr", fault_addr, exp_fa);
        check("R8 pte_new", pte_new, exp_pte);
        check("R10 wb_req", 32'(wb_req), 32'(v.g && (exp_pte != pte_in)));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [31:0] hold_st, hold_pte;
        logic        hold_g;
        rst_n = 1'b0; req_valid = 1'b0; seg_word = '0; user_mode = 1'b0;
        acc_kind = 2'd0; eff_addr = '0; pte_word = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11 reset state
        check("R11 reset rsp_valid", 32'(rsp_valid), 32'd0);
        check("R11 reset grant/fault/wb", 32'({grant, fault, wb_req}), 32'd0);
        check("R11 reset pte_new", pte_new, 32'd0);
        check("R11 reset status", status_code, 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [31:0] ea;
            ea = 32'h1000_0040 + 32'(i) * 32'h0001_1110;
            drive(VECS[i], ea);
            verify(VECS[i], ea, pte_word);
        end

        // R11 hold: inputs change without a request
        hold_st  = status_code;
        hold_pte = pte_new;
        hold_g   = grant;
        seg_word = 32'h7000_0000; acc_kind = 2'd1; pte_word = 32'hFFFF_FFFF; user_mode = 1'b1;
        repeat (3) @(negedge clk);
        check("R11 idle rsp_valid", 32'(rsp_valid), 32'd0);
        check("R11 idle status hold", status_code, hold_st);
        check("R11 idle pte hold", pte_new, hold_pte);
        check("R11 idle grant hold", 32'(hold_g), 32'(grant));

        // R11 back-to-back requests: fault then grant
        @(negedge clk);
        seg_word = 32'h2000_0000; user_mode = 1'b1; acc_kind = 2'd1;
        pte_word = 32'h0000_0000; eff_addr = 32'hDEAD_BEE0; req_valid = 1'b1;
        @(negedge clk);
        check("R7 b2b fault_addr", fault_addr, 32'hDEAD_BEE0);
        check("R10 b2b no wb on fault", 32'(wb_req), 32'd0);
        seg_word = 32'h0000_0000; user_mode = 1'b1; acc_kind = 2'd1;
        pte_word = 32'h0000_0002;
        @(negedge clk);
        req_valid = 1'b0;
        check("R11 b2b second valid", 32'(rsp_valid), 32'd1);
        check("R8 b2b pte_new", pte_new, 32'h0000_0182);
        check("R10 b2b wb_req", 32'(wb_req), 32'd1);
        @(negedge clk);
        check("R11 b2b drop valid", 32'(rsp_valid), 32'd0);

        // R11 reset mid-run clears results
        rst_n = 1'b0;
        @(negedge clk);
        check("R11 re-reset pte_new", pte_new, 32'd0);
        rst_n = 1'b1;
        finish_run();
    end
endmodule